// File: doc/BRIEF.md
# Write-Only Display Command/Data Receiver over I2C

This block is the device side of a two-wire serial link in front of a display controller. It watches already-synchronised SCL and SDA levels, finds start and stop conditions, checks the first byte of each transfer against its own 7-bit address, and pulls SDA low to acknowledge the bytes it takes. The low address bit comes from a strap input, so two such devices can share one bus.

After the address, every byte is sorted by a small control-byte protocol. A control byte decides two things: whether the bytes after it are commands or display data, and whether exactly one payload byte follows before the next control byte or all bytes until the stop are payload. Each payload byte leaves the block as a one-cycle strobe with the byte value and a command/data flag. A level output shows when a transfer is in progress on the bus.

The block never sends data, never holds SCL low, and takes no part in bus arbitration. A transfer that asks to read is not acknowledged.

Top module: `disp_i2c_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `pay_vld_o` and `bus_busy_o` are all 0.
- R2: An address byte whose upper seven bits are 0111100 with `addr_strap_i` = 0, or 0111101 with `addr_strap_i` = 1, and whose bit 0 is 0, is acknowledged: SDA is held low for the whole high phase of the ninth SCL pulse.
- R3: When the address does not match, the block leaves SDA released for the rest of the transfer and emits no payload strobe until the next start condition.
- R4: An address byte that matches but has bit 0 = 1 (read) is not acknowledged, and the transfer is ignored like a mismatch.
- R5: After a matched address, every following byte is acknowledged on its ninth clock.
- R6: A control byte with bit 7 (continuation) = 0 makes every later byte up to the stop a payload byte; bit 6 selects the flag: 0 means command (`pay_is_data_o` = 0), 1 means display data (`pay_is_data_o` = 1).
- R7: A control byte with bit 7 = 1 is followed by exactly one payload byte, flagged by its bit 6; the byte after that is read as a new control byte.
- R8: A repeated start (start with no stop before it) restarts address matching, and the first byte after a matched address is again a control byte.
- R9: `bus_busy_o` goes to 1 after a start condition and back to 0 after a stop condition.
- R10: The block changes its SDA pull only while SCL is low.
- R11: Bits are sampled on SCL rising edges, first bit as the most significant; `pay_byte_o` carries the received byte value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| addr_strap_i | input | 1 | Selects the low address bit |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pay_vld_o | output | 1 | One-cycle strobe for a payload byte |
| pay_is_data_o | output | 1 | 1 = display data, 0 = command, valid with strobe |
| pay_byte_o | output | 8 | Payload byte value, valid with strobe |
| bus_busy_o | output | 1 | 1 between a start and the next stop |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 7-bit address and a base address whose strap-selected low bit gives 0111100 or 0111101. With these values both strap settings, a read request, a mismatched address followed by bytes that must stay silent, both continuation modes with both flag values, and a repeated start into a fresh control byte are all reachable with short transfers. Each SCL phase lasts several system clocks, so the acknowledge level is sampled in the middle of the ninth high phase.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_ACK,
        RX_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        PR_CTRL,
        PR_SINGLE,
        PR_STREAM
    } parse_state_e;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic busy_o
);

    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        scl_rise_o = scl_i & ~line_q.scl;
        scl_fall_o = ~scl_i & line_q.scl;
        start_o    = line_q.scl & scl_i & line_q.sda & ~sda_i;
        stop_o     = line_q.scl & scl_i & ~line_q.sda & sda_i;

        line_d      = line_q;
        line_d.scl  = scl_i;
        line_d.sda  = sda_i;
        if (start_o) begin
            line_d.busy = 1'b1;
        end else if (stop_o) begin
            line_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1, busy: 1'b0};
        end else begin
            line_q <= line_d;
        end
    end

    assign busy_o = line_q.busy;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> busy_o);  // R9
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !busy_o);  // R9

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import disp_i2c_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter logic [6:0]  ADDR_BASE = 7'b0111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              pull_o,
    output logic              done_o,
    output logic [ADDR_W:0]   byte_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              ack_pend;
        logic              pull;
        logic              done;
        logic [BYTE_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [BYTE_W-1:0] shifted;
    logic [ADDR_W-1:0] own_addr;
    logic              addr_hit;

    always_comb begin
        shifted  = {eng_q.shreg[BYTE_W-2:0], sda_i};
        own_addr = {ADDR_BASE[ADDR_W-1:1], strap_i};
        addr_hit = (shifted[BYTE_W-1:1] == own_addr) && !shifted[0];

        eng_d      = eng_q;
        eng_d.done = 1'b0;

        if (stop_i) begin
            eng_d.state    = RX_IDLE;
            eng_d.pull     = 1'b0;
            eng_d.ack_pend = 1'b0;
        end else if (start_i) begin
            eng_d.state    = RX_ADDR;
            eng_d.cnt      = '0;
            eng_d.pull     = 1'b0;
            eng_d.ack_pend = 1'b0;
        end else begin
            unique case (eng_q.state)
                RX_ADDR, RX_DATA: begin
                    if (scl_rise_i && !eng_q.ack_pend) begin
                        eng_d.shreg = shifted;
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                        if (eng_q.cnt == LAST_BIT) begin
                            if (eng_q.state == RX_ADDR) begin
                                if (addr_hit) begin
                                    eng_d.ack_pend = 1'b1;
                                end else begin
                                    eng_d.state = RX_SKIP;
                                end
                            end else begin
                                eng_d.ack_pend = 1'b1;
                                eng_d.done     = 1'b1;
                                eng_d.data     = shifted;
                            end
                        end
                    end else if (scl_fall_i && eng_q.ack_pend) begin
                        eng_d.pull     = 1'b1;
                        eng_d.ack_pend = 1'b0;
                        eng_d.state    = RX_ACK;
                    end
                end
                RX_ACK: begin
                    if (scl_fall_i) begin
                        eng_d.pull  = 1'b0;
                        eng_d.cnt   = '0;
                        eng_d.state = RX_DATA;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '{state: RX_IDLE, cnt: '0, shreg: '0, ack_pend: 1'b0,
                       pull: 1'b0, done: 1'b0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign pull_o = eng_q.pull;
    assign done_o = eng_q.done;
    assign byte_o = eng_q.data;

    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == RX_SKIP) |-> !eng_q.pull);  // R3
    AST_ACK_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.pull) |-> ($past(eng_q.cnt) == FULL_CNT));  // R5
    AST_DONE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.done |-> (eng_q.state == RX_DATA));  // R11

endmodule

// File: rtl/i2c_ctrl_decoder.sv
module i2c_ctrl_decoder
    import disp_i2c_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CO_BIT = 7,
    parameter int DC_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              vld_o,
    output logic              is_data_o,
    output logic [BYTE_W-1:0] data_o
);

    typedef struct packed {
        parse_state_e      state;
        logic              dc;
        logic              vld;
        logic              is_data;
        logic [BYTE_W-1:0] data;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = 1'b0;
        if (restart_i) begin
            dec_d.state = PR_CTRL;
        end else if (byte_done_i) begin
            unique case (dec_q.state)
                PR_CTRL: begin
                    dec_d.dc    = byte_i[DC_BIT];
                    dec_d.state = byte_i[CO_BIT] ? PR_SINGLE : PR_STREAM;
                end
                PR_SINGLE: begin
                    dec_d.vld     = 1'b1;
                    dec_d.is_data = dec_q.dc;
                    dec_d.data    = byte_i;
                    dec_d.state   = PR_CTRL;
                end
                default: begin
                    dec_d.vld     = 1'b1;
                    dec_d.is_data = dec_q.dc;
                    dec_d.data    = byte_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '{state: PR_CTRL, dc: 1'b0, vld: 1'b0, is_data: 1'b0, data: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign vld_o     = dec_q.vld;
    assign is_data_o = dec_q.is_data;
    assign data_o    = dec_q.data;

    AST_SINGLE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.state == PR_SINGLE && byte_done_i && !restart_i) |=> (dec_q.state == PR_CTRL));  // R7
    AST_STREAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.state == PR_STREAM && !restart_i) |=> (dec_q.state == PR_STREAM));  // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);  // R6

endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave #(
    parameter int         ADDR_W    = 7,
    parameter logic [6:0] ADDR_BASE = 7'b0111100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_strap_i,
    output logic             sda_pull_o,
    output logic             pay_vld_o,
    output logic             pay_is_data_o,
    output logic [ADDR_W:0]  pay_byte_o,
    output logic             bus_busy_o
);

    localparam int BYTE_W = ADDR_W + 1;

    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_byte;

    i2c_line_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .busy_o     (bus_busy_o)
    );

    i2c_byte_engine #(
        .ADDR_W    (ADDR_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_i      (sda_i),
        .strap_i    (addr_strap_i),
        .pull_o     (sda_pull_o),
        .done_o     (rx_done),
        .byte_o     (rx_byte)
    );

    i2c_ctrl_decoder #(
        .BYTE_W (BYTE_W),
        .CO_BIT (BYTE_W - 1),
        .DC_BIT (BYTE_W - 2)
    ) u_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (start_det),
        .byte_done_i (rx_done),
        .byte_i      (rx_byte),
        .vld_o       (pay_vld_o),
        .is_data_o   (pay_is_data_o),
        .data_o      (pay_byte_o)
    );

    AST_PULL_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));  // R10
    AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy_o |-> !sda_pull_o);  // R3

endmodule

// File: tb/disp_i2c_slave_tb.sv
module disp_i2c_slave_tb;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_line;
    logic       sda_pull;
    logic       pay_vld;
    logic       pay_is_data;
    logic [7:0] pay_byte;
    logic       bus_busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic       is_data;
        logic [7:0] value;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    disp_i2c_slave u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .addr_strap_i  (strap),
        .sda_pull_o    (sda_pull),
        .pay_vld_o     (pay_vld),
        .pay_is_data_o (pay_is_data),
        .pay_byte_o    (pay_byte),
        .bus_busy_o    (bus_busy)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pay(input logic is_data, input logic [7:0] v);
        exp_q.push_back('{is_data: is_data, value: v});
    endtask

    // Monitor: every strobe pops one expected item
    always @(negedge clk) begin
        if (rst_n && pay_vld) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected strobe", {23'd0, pay_is_data, pay_byte}, 32'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R6/R7/R11 payload", {23'd0, pay_is_data, pay_byte}, {23'd0, e.is_data, e.value});
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        check(tag, {31'd0, ~sda_line}, {31'd0, exp_ack});
        tick(H / 2);
        scl_m = 1'b0; tick(1);
    endtask

    initial begin
        tick(4);
        check("R1 sda_pull reset", {31'd0, sda_pull}, 32'd0);
        check("R1 pay_vld reset", {31'd0, pay_vld}, 32'd0);
        check("R1 bus_busy reset", {31'd0, bus_busy}, 32'd0);
        rst_n = 1'b1;
        tick(4);

        // Streamed commands, strap low
        strap = 1'b0;
        bus_start();
        check("R9 busy after start", {31'd0, bus_busy}, 32'd1);
        send_byte(8'h78, 1'b1, "R2 ack addr strap0");
        send_byte(8'h00, 1'b1, "R5 ack ctrl");
        expect_pay(1'b0, 8'hAE); send_byte(8'hAE, 1'b1, "R5 ack cmd");
        expect_pay(1'b0, 8'hA8); send_byte(8'hA8, 1'b1, "R5 ack cmd");
        expect_pay(1'b0, 8'h3F); send_byte(8'h3F, 1'b1, "R5 ack cmd");
        bus_stop();
        check("R9 idle after stop", {31'd0, bus_busy}, 32'd0);

        // Streamed display data; 0x80 in a stream is payload, not control (R6)
        bus_start();
        send_byte(8'h78, 1'b1, "R2 ack addr");
        send_byte(8'h40, 1'b1, "R5 ack ctrl data");
        expect_pay(1'b1, 8'h55); send_byte(8'h55, 1'b1, "R11 data 55");
        expect_pay(1'b1, 8'h80); send_byte(8'h80, 1'b1, "R6 data 80");
        expect_pay(1'b1, 8'h01); send_byte(8'h01, 1'b1, "R11 data 01");
        bus_stop();

        // Single-byte control mode (R7)
        bus_start();
        send_byte(8'h78, 1'b1, "R2 ack addr");
        send_byte(8'h80, 1'b1, "R7 ctrl single cmd");
        expect_pay(1'b0, 8'hAF); send_byte(8'hAF, 1'b1, "R7 single cmd");
        send_byte(8'hC0, 1'b1, "R7 ctrl single data");
        expect_pay(1'b1, 8'h12); send_byte(8'h12, 1'b1, "R7 single data");
        send_byte(8'h00, 1'b1, "R7 ctrl to stream");
        expect_pay(1'b0, 8'h81); send_byte(8'h81, 1'b1, "R7 stream cmd");
        expect_pay(1'b0, 8'h7F); send_byte(8'h7F, 1'b1, "R7 stream cmd");
        bus_stop();

        // Strap high: old address mismatches and is ignored (R3)
        strap = 1'b1;
        bus_start();
        send_byte(8'h78, 1'b0, "R3 no ack mismatch");
        send_byte(8'h40, 1'b0, "R3 no ack after mismatch");
        send_byte(8'h33, 1'b0, "R3 no ack after mismatch");
        bus_stop();
        bus_start();
        send_byte(8'h7A, 1'b1, "R2 ack addr strap1");
        send_byte(8'h40, 1'b1, "R5 ack ctrl");
        expect_pay(1'b1, 8'h99); send_byte(8'h99, 1'b1, "R2 data after strap1");
        bus_stop();

        // Read request (R4)
        bus_start();
        send_byte(8'h7B, 1'b0, "R4 no ack read");
        send_byte(8'h40, 1'b0, "R4 ignored after read");
        send_byte(8'h44, 1'b0, "R4 ignored after read");
        bus_stop();

        // Repeated start (R8)
        strap = 1'b0;
        bus_start();
        send_byte(8'h78, 1'b1, "R2 ack addr");
        send_byte(8'h40, 1'b1, "R5 ack ctrl");
        expect_pay(1'b1, 8'h11); send_byte(8'h11, 1'b1, "R8 data before rs");
        bus_start();
        check("R8 busy across repeated start", {31'd0, bus_busy}, 32'd1);
        send_byte(8'h78, 1'b1, "R8 ack addr after rs");
        send_byte(8'h00, 1'b1, "R8 ctrl after rs");
        expect_pay(1'b0, 8'h22); send_byte(8'h22, 1'b1, "R8 cmd after rs");
        bus_start();
        send_byte(8'h7A, 1'b0, "R8 mismatch after rs");
        send_byte(8'h40, 1'b0, "R3 silent after rs mismatch");
        bus_stop();

        tick(20);
        check("R3 no stray or missing strobes", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule